// File: doc/BRIEF.md
# Sub-Ranging Shift-Add Code Assembler

This block assembles the output word of a multi-cycle sub-ranging converter. A sample is converted in a fixed number of cycles. In each cycle a low-resolution pre-converter delivers a short coarse code. The block places that code at a cycle-dependent bit weight and adds it to a running partial code. Each cycle may reserve a few low bits that overlap the next cycle's code. A later code can therefore push the partial code up or down and cancel an error made in an earlier cycle, which plain concatenation cannot do.

A `start` pulse opens a sample and clears the partial code. Each coarse code arrives with a one-clock `code_vld` strobe. One clock later the corrected partial code appears on `fb_code`, which drives the feedback DAC, together with a one-clock `fb_upd` pulse. After the last cycle the final code is latched on `final_code` and `done` pulses for one clock. Samples do not depend on each other.

The number of cycles, the coarse width and the overlap of each cycle are parameters. The overlaps are packed as 4-bit fields in `OVL_MAP`, with field k holding the overlap of cycle k (0-based). The final resolution RES is the sum over all cycles of (coarse width − overlap). The last cycle's overlap must be zero. The defaults are 4 cycles, a 4-bit coarse code and overlaps {1,1,1,0}, which give RES = 13.

Top module: `subrange_code_asm`

## Requirements
- R1: While reset is held and in the first cycle after it, `fb_code`, `final_code`, `fb_upd` and `done` are all zero.
- R2: A `start` pulse clears the partial code. One clock later `fb_code` is zero and `fb_upd` is low. A `start` during a conversion abandons that sample. A `start` in the same clock as `code_vld` takes priority, and that code is discarded.
- R3: The code accepted in cycle k (0-based) is added at weight 2^W(k). W(k) is the sum of (coarse width − overlap) over all later cycles, minus the overlap of cycle k. With the defaults the weights are 2^9, 2^6, 2^3 and 2^0.
- R4: With `FIRST_UNSIGNED` = 1 (the default), the cycle-0 code is unsigned (0..15). The codes of all later cycles are 4-bit two's complement (−8..7), so a later code can reduce the accumulated value.
- R5: One clock after each accepted code, `fb_code` shows the saturated new partial code and `fb_upd` is high for exactly that clock. At other times `fb_code` holds its value.
- R6: One clock after the last code of a sample is accepted, `done` is high for one clock. In that same clock `final_code` equals the saturated full sum, and `fb_upd` is also high. `final_code` holds until the next `done`.
- R7: The block keeps the exact sum internally, with a sign bit and one guard bit. It clamps only the outputs: a negative sum reads as 0, and a sum above 2^RES−1 reads as 2^RES−1.
- R8: A `code_vld` outside a conversion is ignored. It causes no `fb_upd` and no `done`, and it leaves `fb_code` and `final_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new sample and clears the partial code |
| code_vld | input | 1 | Strobe marking `code_in` as valid |
| code_in | input | CW | Coarse pre-converter code |
| fb_code | output | RES | Saturated partial code for the feedback DAC |
| fb_upd | output | 1 | One-clock pulse marking an update of `fb_code` |
| final_code | output | RES | Saturated code of the last finished sample |
| done | output | 1 | One-clock pulse when `final_code` is updated |

## Verification
A wrong cycle index or weight table puts a code at the wrong bit weight. This shows up on `fb_code` one clock after that code is accepted. A wrong sign extension is visible as soon as a negative correction arrives. An accumulator that is not cleared, or that keeps running after an abandoned sample, corrupts the first feedback value of the next sample. A miscounted cycle total moves `done` away from the clock after the last code, or makes it fire in the wrong clock.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;

   localparam int MAX_CYC = 8;
   localparam int OVL_FLD = 4;
   localparam int MAP_W   = MAX_CYC * OVL_FLD;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } asm_state_e;

   // overlap reserved by cycle k
   function automatic int ovl_at(input logic [MAP_W-1:0] map, input int k);
      return int'(map[k*OVL_FLD +: OVL_FLD]);
   endfunction

   // final resolution: sum of net bits contributed per cycle
   function automatic int res_bits(input int cw, input int ncyc, input logic [MAP_W-1:0] map);
      int r;
      r = 0;
      for (int k = 0; k < ncyc; k++) r += cw - ovl_at(map, k);
      return r;
   endfunction

   // bit weight of the code accepted in cycle k
   function automatic int weight_of(input int cw, input int ncyc,
                                    input logic [MAP_W-1:0] map, input int k);
      int s;
      s = 0;
      for (int i = k + 1; i < ncyc; i++) s += cw - ovl_at(map, i);
      return s - ovl_at(map, k);
   endfunction

endpackage

// File: rtl/sra_seq_ctrl.sv
`timescale 1ns/1ps
module sra_seq_ctrl #(
   parameter int N_CYC = 4,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             code_vld,
   output logic             busy,
   output logic             accept,
   output logic             last,
   output logic [CNT_W-1:0] cyc_idx
);
   import sra_pkg::*;

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_CYC - 1);

   asm_state_e state_q;
   logic [CNT_W-1:0] idx_q;

   assign busy    = (state_q == ST_BUSY);
   assign accept  = code_vld && busy && !start;
   assign last    = accept && (idx_q == LAST_IDX);
   assign cyc_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else if (start) begin
         state_q <= ST_BUSY;
         idx_q   <= '0;
      end else if (accept) begin
         if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sra_addend_gen.sv
`timescale 1ns/1ps
module sra_addend_gen #(
   parameter int                         CW             = 4,
   parameter int                         N_CYC          = 4,
   parameter logic [sra_pkg::MAP_W-1:0]  OVL_MAP        = 32'h0000_0111,
   parameter bit                         FIRST_UNSIGNED = 1'b1,
   parameter int                         ACC_W          = 15,
   parameter int                         CNT_W          = 2
) (
   input  logic [CW-1:0]           code_in,
   input  logic [CNT_W-1:0]        cyc_idx,
   output logic signed [ACC_W-1:0] addend
);
   import sra_pkg::*;

   logic signed [ACC_W-1:0] term [N_CYC];

   for (genvar k = 0; k < N_CYC; k++) begin : g_term
      localparam int WGT = weight_of(CW, N_CYC, OVL_MAP, k);
      logic signed [ACC_W-1:0] ext;
      if (k == 0 && FIRST_UNSIGNED) begin : g_uns
         assign ext = {{(ACC_W-CW){1'b0}}, code_in};
      end else begin : g_sgn
         assign ext = {{(ACC_W-CW){code_in[CW-1]}}, code_in};
      end
      assign term[k] = ext <<< WGT;
   end

   always_comb begin
      addend = '0;
      for (int k = 0; k < N_CYC; k++) begin
         if (cyc_idx == CNT_W'(k)) addend = term[k];
      end
   end

endmodule

// File: rtl/sra_accum.sv
`timescale 1ns/1ps
module sra_accum #(
   parameter int RES   = 13,
   parameter int ACC_W = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    accept,
   input  logic                    last,
   input  logic signed [ACC_W-1:0] addend,
   output logic [RES-1:0]          fb_code,
   output logic                    fb_upd,
   output logic [RES-1:0]          final_code,
   output logic                    done
);
   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-RES){1'b0}}, {RES{1'b1}}};

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] sum;
   logic [RES-1:0]          sat;

   assign sum = acc_q + addend;

   always_comb begin
      if (sum < 0)         sat = '0;
      else if (sum > MAXV) sat = '1;
      else                 sat = sum[RES-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         fb_code    <= '0;
         fb_upd     <= 1'b0;
         final_code <= '0;
         done       <= 1'b0;
      end else begin
         fb_upd <= accept;
         done   <= last;
         if (clear) begin
            acc_q   <= '0;
            fb_code <= '0;
         end else if (accept) begin
            acc_q   <= sum;
            fb_code <= sat;
         end
         if (last) final_code <= sat;
      end
   end

endmodule

// File: rtl/subrange_code_asm.sv
`timescale 1ns/1ps
module subrange_code_asm #(
   parameter int                        N_CYC          = 4,
   parameter int                        CW             = 4,
   parameter logic [sra_pkg::MAP_W-1:0] OVL_MAP        = 32'h0000_0111,
   parameter bit                        FIRST_UNSIGNED = 1'b1,
   localparam int RES   = sra_pkg::res_bits(CW, N_CYC, OVL_MAP),
   localparam int ACC_W = RES + 2,
   localparam int CNT_W = $clog2(N_CYC)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           code_vld,
   input  logic [CW-1:0]  code_in,
   output logic [RES-1:0] fb_code,
   output logic           fb_upd,
   output logic [RES-1:0] final_code,
   output logic           done
);
   import sra_pkg::*;

   // elaboration-time parameter checks
   if (CW < 1 || CW > 6) begin : g_bad_cw
      $error("coarse width must lie in 1..6");
   end
   if (N_CYC < 2 || N_CYC > MAX_CYC) begin : g_bad_ncyc
      $error("cycle count out of range");
   end
   if (ovl_at(OVL_MAP, N_CYC - 1) != 0) begin : g_bad_last
      $error("last cycle must reserve no overlap");
   end
   for (genvar k = 0; k < N_CYC; k++) begin : g_chk
      if (ovl_at(OVL_MAP, k) >= CW) begin : g_bad_ovl
         $error("overlap must be smaller than the coarse width");
      end
      if (weight_of(CW, N_CYC, OVL_MAP, k) < 0) begin : g_bad_wgt
         $error("overlap map gives a negative weight");
      end
   end

   logic                    busy;
   logic                    accept;
   logic                    last;
   logic [CNT_W-1:0]        cyc_idx;
   logic signed [ACC_W-1:0] addend;

   sra_seq_ctrl #(
      .N_CYC (N_CYC),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .code_vld (code_vld),
      .busy     (busy),
      .accept   (accept),
      .last     (last),
      .cyc_idx  (cyc_idx)
   );

   sra_addend_gen #(
      .CW             (CW),
      .N_CYC          (N_CYC),
      .OVL_MAP        (OVL_MAP),
      .FIRST_UNSIGNED (FIRST_UNSIGNED),
      .ACC_W          (ACC_W),
      .CNT_W          (CNT_W)
   ) u_addend (
      .code_in (code_in),
      .cyc_idx (cyc_idx),
      .addend  (addend)
   );

   sra_accum #(
      .RES   (RES),
      .ACC_W (ACC_W)
   ) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .accept     (accept),
      .last       (last),
      .addend     (addend),
      .fb_code    (fb_code),
      .fb_upd     (fb_upd),
      .final_code (final_code),
      .done       (done)
   );

endmodule

// File: rtl/sra_asm_checker.sv
`timescale 1ns/1ps
module sra_asm_checker #(
   parameter int N_CYC = 4,
   parameter int RES   = 13
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           code_vld,
   input logic           busy,
   input logic [RES-1:0] fb_code,
   input logic           fb_upd,
   input logic [RES-1:0] final_code,
   input logic           done
);
   int upd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_cnt <= 0;
      else if (start)  upd_cnt <= 0;
      else if (fb_upd) upd_cnt <= upd_cnt + 1;
   end

   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (fb_code == '0 && !fb_upd));

   a_r5_upd_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld && busy && !start) |=> fb_upd);

   a_r5_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_upd && !$past(start)) |-> $stable(fb_code));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fb_upd && final_code == fb_code));

   a_r6_final_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(final_code));

   a_r6_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (upd_cnt == N_CYC - 1));

   a_r8_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (code_vld && !busy) |=> !fb_upd);

endmodule

bind subrange_code_asm sra_asm_checker #(
   .N_CYC (N_CYC),
   .RES   (RES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .code_vld   (code_vld),
   .busy       (busy),
   .fb_code    (fb_code),
   .fb_upd     (fb_upd),
   .final_code (final_code),
   .done       (done)
);

// File: tb/sim_subrange_code_asm.sv
`timescale 1ns/1ps
module sim_subrange_code_asm;

   localparam int RES  = 13;
   localparam int MAXV = (1 << RES) - 1;
   localparam int OFFS [4] = '{9, 6, 3, 0};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           code_vld = 1'b0;
   logic [3:0]     code_in = '0;
   logic [RES-1:0] fb_code;
   logic           fb_upd;
   logic [RES-1:0] final_code;
   logic           done;

   int  n_chk = 0;
   int  n_bad = 0;
   int  exp_final = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   subrange_code_asm u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .code_vld   (code_vld),
      .code_in    (code_in),
      .fb_code    (fb_code),
      .fb_upd     (fb_upd),
      .final_code (final_code),
      .done       (done)
   );

   // R3/R4 model: exact weighted sum of codes 0..upto
   function automatic int part_sum(input int c[4], input int upto);
      int s;
      int v;
      s = 0;
      for (int k = 0; k <= upto; k++) begin
         v = c[k];
         if (k != 0 && v >= 8) v = v - 16;
         s += v * (1 << OFFS[k]);
      end
      return s;
   endfunction

   // R7 output clamp
   function automatic int sat(input int s);
      if (s < 0)    return 0;
      if (s > MAXV) return MAXV;
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fb_code == 0, "R2 fb_code after start", int'(fb_code), 0);
      chk(!fb_upd, "R2 no fb_upd after start", int'(fb_upd), 0);
   endtask

   task automatic send(input int c);
      code_vld = 1'b1;
      code_in  = 4'(c);
      @(negedge clk);
      code_vld = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic run_sample(input int c[4], input int max_gap);
      int e;
      do_start();
      for (int k = 0; k < 4; k++) begin
         if (max_gap > 0) idle($urandom_range(max_gap, 0));
         send(c[k]);
         e = sat(part_sum(c, k));
         chk(int'(fb_code) == e, "R3/R4/R5 partial code", int'(fb_code), e);
         chk(fb_upd == 1'b1, "R5 fb_upd pulse", int'(fb_upd), 1);
         if (k < 3) begin
            chk(!done, "R6 no early done", int'(done), 0);
            chk(int'(final_code) == exp_final, "R6 final holds", int'(final_code), exp_final);
         end else begin
            chk(done == 1'b1, "R6 done after last code", int'(done), 1);
            chk(int'(final_code) == e, "R6 final code", int'(final_code), e);
            exp_final = e;
         end
      end
      idle(1);
      chk(!done, "R6 done one clock", int'(done), 0);
      chk(!fb_upd, "R5 fb_upd one clock", int'(fb_upd), 0);
   endtask

   initial begin
      int c[4];
      int s;
      void'($urandom(32'd20240611));
      idle(3);
      chk(fb_code == 0 && final_code == 0 && !done && !fb_upd, "R1 state in reset",
          int'(fb_code) + int'(final_code) + int'(done) + int'(fb_upd), 0);
      rst_n = 1'b1;
      idle(1);
      chk(fb_code == 0 && final_code == 0 && !done && !fb_upd, "R1 state after reset",
          int'(fb_code) + int'(final_code) + int'(done) + int'(fb_upd), 0);

      // R8: code while idle
      send(9);
      chk(!fb_upd && fb_code == 0, "R8 idle code ignored", int'(fb_upd) + int'(fb_code), 0);
      chk(!done && final_code == 0, "R8 idle no done", int'(done) + int'(final_code), 0);

      // R3: weights 2^9, 2^6, 2^3, 2^0
      c = '{1, 0, 0, 0}; run_sample(c, 0);
      c = '{0, 1, 0, 0}; run_sample(c, 0);
      c = '{0, 0, 1, 0}; run_sample(c, 0);
      c = '{0, 0, 0, 1}; run_sample(c, 0);
      c = '{15, 7, 7, 7}; run_sample(c, 0);
      chk(int'(final_code) == 8191, "R3 full scale", int'(final_code), 8191);
      // R4: negative correction
      c = '{5, 15, 0, 0}; run_sample(c, 0);
      chk(int'(final_code) == 2496, "R4 negative correction", int'(final_code), 2496);
      // R4: unsigned first code, value 12 must not be negative
      c = '{12, 0, 0, 0}; run_sample(c, 0);
      chk(int'(final_code) == 6144, "R4 first code unsigned", int'(final_code), 6144);
      // R7: clamp at zero, exact value kept internally
      c = '{0, 8, 7, 7}; run_sample(c, 0);
      chk(int'(final_code) == 0, "R7 low clamp", int'(final_code), 0);
      c = '{1, 8, 1, 0}; run_sample(c, 0);
      chk(int'(final_code) == 8, "R7 exact internal sum", int'(final_code), 8);

      // R8: code after done ignored
      send(5);
      chk(!fb_upd && int'(fb_code) == 8, "R8 post-done code ignored", int'(fb_code), 8);
      chk(!done && int'(final_code) == 8, "R8 final unchanged", int'(final_code), 8);

      // R2: abandon a sample midway
      do_start();
      send(7);
      send(3);
      c = '{3, 0, 0, 0}; run_sample(c, 0);
      chk(int'(final_code) == 1536, "R2 abort restarts", int'(final_code), 1536);

      // R2: start together with a code
      start = 1'b1; code_vld = 1'b1; code_in = 4'd7;
      @(negedge clk);
      start = 1'b0; code_vld = 1'b0;
      chk(fb_code == 0 && !fb_upd, "R2 start beats code", int'(fb_code) + int'(fb_upd), 0);
      for (int k = 0; k < 4; k++) begin
         send(k == 0 ? 4 : 0);
         s = (k == 3) ? int'(done) : 1;
         chk(s == 1, "R2 four codes after start", s, 1);
      end
      chk(int'(final_code) == 2048, "R2 discarded code", int'(final_code), 2048);
      exp_final = 2048;
      idle(1);

      // random samples with gaps
      for (int n = 0; n < 150; n++) begin
         for (int k = 0; k < 4; k++) c[k] = $urandom_range(15, 0);
         run_sample(c, 2);
         if ($urandom_range(3, 0) == 0) begin
            send($urandom_range(15, 0));
            chk(!fb_upd && int'(final_code) == exp_final, "R8 random idle code",
                int'(final_code), exp_final);
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule